// File: doc/BRIEF.md
# DMA Channel Address and Count Register File

This block holds the programmable address and count state for a four-channel DMA controller that software reaches through an 8-bit I/O port. Each channel keeps a 16-bit base address, a 16-bit base count, a current address and a counter of bytes moved since the last reload. Because the port is only one byte wide, 16-bit values go in and come out as two byte accesses. One byte-pointer flip-flop is shared by all channels. It chooses the low or the high byte and flips after every access.

Software reads back live values. The count reads as what remains: the base count minus the bytes already moved. The address reads as the current address shifted by the bytes moved, up or down according to the channel's direction input. The transfer engine itself is not part of this block. It shows up only as one strobe per channel, pulsed for every byte moved. A parameter builds a word-wide variant in which the port offset and the read-back values are shifted right by one, so that addresses and counts are counted in 16-bit words.

Top module: `xfer_chan_regfile`

## Requirements
- R1: Channel registers are selected by the offset `port_addr >> WSHIFT`. Bit 0 of that offset picks the address register (0) or the count register (1). Bits 2:1 give the channel number.
- R2: An internal byte pointer is 0 after reset. A channel-register access reaches the low byte when the pointer is 0 and the high byte when it is 1. Any accepted read or write flips the pointer, and it holds when there is no access.
- R3: A low-byte write changes only bits 7:0 of the selected base register. A high-byte write changes only bits 15:8.
- R4: A high-byte write to either register of a channel reloads that channel: the current address becomes the new base address (in bytes) and its transferred counter goes to zero. A low-byte write reloads nothing.
- R5: A count read returns the base count minus the bytes transferred, modulo 2^16 in the read unit.
- R6: An address read returns the current address plus the bytes transferred when `dir_down[ch]` is 0, and minus them when it is 1.
- R7: `ptr_clr` clears the byte pointer. In the same cycle it suppresses any write and any pointer flip.
- R8: Each cycle that `xfer_stb[ch]` is high adds one to that channel's transferred counter. A reload of the same channel in the same cycle takes precedence and leaves the counter at zero. Other channels are not affected.
- R9: After reset all base, current and counter registers read as zero.
- R10: With WSHIFT=1 the internal address and counter are byte-granular and one bit wider, and both read-back values are shifted right by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_addr | input | 3+WSHIFT | Channel-register port offset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe (advances the pointer) |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte for the current offset and pointer |
| ptr_clr | input | 1 | Byte-pointer clear command |
| dir_down | input | NCH | Per-channel direction: 1 = address decrements |
| xfer_stb | input | NCH | Per-channel byte-moved strobe |

## Verification
The hardest situations to reach are the collisions: a reload and a transfer strobe on the same channel in the same cycle, and a pointer clear that lands on a write. The stimulus drives both collisions directly. It then reads the count to show that the counter stayed at zero, and the address to show that the write was dropped. Wraparound below zero is reached by loading a zero count and strobing. The word-wide instance gets the same stimulus as the byte instance, so every shifted value is compared next to the byte-mode value.

// File: rtl/xfer_regs_pkg.sv
package xfer_regs_pkg;
  localparam int REG_W  = 16;
  localparam int BYTE_W = 8;

  typedef enum logic {
    KIND_ADDR = 1'b0,
    KIND_CNT  = 1'b1
  } reg_kind_e;
endpackage

// File: rtl/xfer_rst_sync.sv
module xfer_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ns = sync_q[1];
endmodule

// File: rtl/xfer_byte_ptr.sv
module xfer_byte_ptr (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output logic ptr
);
  logic ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (clr)       ptr_d = 1'b0;
    else if (step) ptr_d = ~ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= 1'b0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/xfer_chan_slot.sv
module xfer_chan_slot
  import xfer_regs_pkg::*;
#(
  parameter int WSHIFT = 0,
  localparam int CW = REG_W + WSHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  reg_kind_e         kind,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              stb,
  input  logic              dir_down,
  output logic [REG_W-1:0]  rd_addr,
  output logic [REG_W-1:0]  rd_cnt,
  output logic [CW-1:0]     done_o,
  output logic [REG_W-1:0]  base_addr_o
);
  logic [REG_W-1:0] base_addr_q, base_addr_d;
  logic [REG_W-1:0] base_cnt_q, base_cnt_d;
  logic [CW-1:0]    cur_q, cur_d;
  logic [CW-1:0]    done_q, done_d;
  logic             base_en, cur_en, done_en;
  logic [CW-1:0]    addr_full, cnt_full;

  // next-state for base registers
  always_comb begin
    base_addr_d = base_addr_q;
    base_cnt_d  = base_cnt_q;
    if (kind == KIND_ADDR) begin
      if (wr_lo) base_addr_d[BYTE_W-1:0]     = wdata;
      if (wr_hi) base_addr_d[REG_W-1:BYTE_W] = wdata;
    end else begin
      if (wr_lo) base_cnt_d[BYTE_W-1:0]      = wdata;
      if (wr_hi) base_cnt_d[REG_W-1:BYTE_W]  = wdata;
    end
  end

  // next-state for current address and transferred counter
  always_comb begin
    cur_d  = cur_q;
    done_d = done_q;
    if (wr_hi) begin
      cur_d  = CW'(base_addr_d) << WSHIFT;
      done_d = '0;
    end else if (stb) begin
      done_d = done_q + CW'(1);
    end
  end

  assign base_en = wr_lo | wr_hi;
  assign cur_en  = wr_hi;
  assign done_en = wr_hi | stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
    end else if (base_en) begin
      base_addr_q <= base_addr_d;
      base_cnt_q  <= base_cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_q <= '0;
    else if (cur_en) cur_q <= cur_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       done_q <= '0;
    else if (done_en) done_q <= done_d;
  end

  // live read-back values
  assign addr_full   = dir_down ? (cur_q - done_q) : (cur_q + done_q);
  assign cnt_full    = (CW'(base_cnt_q) << WSHIFT) - done_q;
  assign rd_addr     = addr_full[WSHIFT +: REG_W];
  assign rd_cnt      = cnt_full[WSHIFT +: REG_W];
  assign done_o      = done_q;
  assign base_addr_o = base_addr_q;
endmodule

// File: rtl/xfer_chan_regfile.sv
module xfer_chan_regfile
  import xfer_regs_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int WSHIFT = 0,
  localparam int IDX_W = $clog2(NCH),
  localparam int PA_W  = IDX_W + 1 + WSHIFT,
  localparam int CW    = REG_W + WSHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PA_W-1:0]   port_addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic              ptr_clr,
  input  logic [NCH-1:0]    dir_down,
  input  logic [NCH-1:0]    xfer_stb
);
  logic                             rst_ns;
  logic                             ptr;
  logic [IDX_W:0]                   sel;
  logic [IDX_W-1:0]                 chan;
  reg_kind_e                        kind;
  logic                             wr_act, step;
  logic [NCH-1:0]                   wr_lo, wr_hi;
  logic [NCH-1:0][REG_W-1:0]        rd_addr, rd_cnt, base_addr;
  logic [NCH-1:0][CW-1:0]           done;
  logic [REG_W-1:0]                 word;

  xfer_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  assign sel    = port_addr[WSHIFT +: IDX_W+1];
  assign chan   = sel[IDX_W:1];
  assign kind   = reg_kind_e'(sel[0]);
  assign wr_act = wr_en & ~ptr_clr;
  assign step   = (wr_en | rd_en) & ~ptr_clr;

  xfer_byte_ptr u_ptr (
    .clk   (clk),
    .rst_n (rst_ns),
    .clr   (ptr_clr),
    .step  (step),
    .ptr   (ptr)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    assign wr_lo[c] = wr_act & ~ptr & (chan == IDX_W'(c));
    assign wr_hi[c] = wr_act &  ptr & (chan == IDX_W'(c));

    xfer_chan_slot #(.WSHIFT(WSHIFT)) u_slot (
      .clk         (clk),
      .rst_n       (rst_ns),
      .wr_lo       (wr_lo[c]),
      .wr_hi       (wr_hi[c]),
      .kind        (kind),
      .wdata       (wdata),
      .stb         (xfer_stb[c]),
      .dir_down    (dir_down[c]),
      .rd_addr     (rd_addr[c]),
      .rd_cnt      (rd_cnt[c]),
      .done_o      (done[c]),
      .base_addr_o (base_addr[c])
    );
  end

  always_comb begin
    word  = (kind == KIND_CNT) ? rd_cnt[chan] : rd_addr[chan];
    rdata = ptr ? word[REG_W-1:BYTE_W] : word[BYTE_W-1:0];
  end
endmodule

// File: rtl/xfer_chan_regfile_chk.sv
module xfer_chan_regfile_chk #(
  parameter int NCH    = 4,
  parameter int WSHIFT = 0,
  localparam int IDX_W = $clog2(NCH),
  localparam int PA_W  = IDX_W + 1 + WSHIFT,
  localparam int CW    = 16 + WSHIFT
) (
  input logic                      clk,
  input logic                      rst_ns,
  input logic                      ptr,
  input logic                      wr_en,
  input logic                      rd_en,
  input logic                      ptr_clr,
  input logic [PA_W-1:0]           port_addr,
  input logic [NCH-1:0]            xfer_stb,
  input logic [NCH-1:0][CW-1:0]    done,
  input logic [NCH-1:0][15:0]      base_addr
);
  logic [IDX_W:0] sel;
  assign sel = port_addr[WSHIFT +: IDX_W+1];

  a_r7_clear_ptr: assert property (@(posedge clk) disable iff (!rst_ns)
    ptr_clr |=> !ptr);

  a_r2_ptr_flip: assert property (@(posedge clk) disable iff (!rst_ns)
    ((wr_en || rd_en) && !ptr_clr) |=> (ptr != $past(ptr)));

  a_r2_ptr_hold: assert property (@(posedge clk) disable iff (!rst_ns)
    (!wr_en && !rd_en && !ptr_clr) |=> $stable(ptr));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    logic hit, reload;
    assign hit    = wr_en && !ptr_clr && (sel[IDX_W:1] == IDX_W'(c));
    assign reload = hit && ptr;

    a_r4_reload_zero: assert property (@(posedge clk) disable iff (!rst_ns)
      reload |=> (done[c] == '0));

    a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_ns)
      (xfer_stb[c] && !reload) |=> (done[c] == $past(done[c]) + CW'(1)));

    a_r8_count_idle: assert property (@(posedge clk) disable iff (!rst_ns)
      (!xfer_stb[c] && !reload) |=> $stable(done[c]));

    a_r3_low_keeps_high: assert property (@(posedge clk) disable iff (!rst_ns)
      (hit && !ptr && !sel[0]) |=> (base_addr[c][15:8] == $past(base_addr[c][15:8])));
  end
endmodule

bind xfer_chan_regfile xfer_chan_regfile_chk #(.NCH(NCH), .WSHIFT(WSHIFT)) u_chk (
  .clk       (clk),
  .rst_ns    (rst_ns),
  .ptr       (ptr),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .ptr_clr   (ptr_clr),
  .port_addr (port_addr),
  .xfer_stb  (xfer_stb),
  .done      (done),
  .base_addr (base_addr)
);

// File: tb/xfer_chan_regfile_bench.sv
module xfer_chan_regfile_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] ofs = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0, ptr_clr = 1'b0;
  logic [7:0] wdata = '0;
  logic [3:0] dir_down = '0, xfer_stb = '0;
  logic [7:0] rdata_b, rdata_w;

  int    n_tests = 0, n_fail = 0, cycles = 0;
  string cur_req = "R9";

  always #5 clk = ~clk;

  xfer_chan_regfile u_xfer_chan_regfile (
    .clk(clk), .rst_n(rst_n), .port_addr(ofs), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata_b), .ptr_clr(ptr_clr), .dir_down(dir_down),
    .xfer_stb(xfer_stb));

  xfer_chan_regfile #(.WSHIFT(1)) u_xfer_chan_regfile_w (
    .clk(clk), .rst_n(rst_n), .port_addr({ofs, 1'b0}), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata_w), .ptr_clr(ptr_clr), .dir_down(dir_down),
    .xfer_stb(xfer_stb));

  // behavioural reference: index 0 = byte instance, 1 = word instance (R10)
  int m_ba[2][4], m_bc[2][4], m_cur[2][4], m_done[2][4];
  int m_ff[2];

  function automatic int expect_rd(int i);
    int ch, mask, v;
    ch   = int'(ofs[2:1]);
    mask = (1 << (16 + i)) - 1;
    if (ofs[0]) v = ((m_bc[i][ch] << i) - m_done[i][ch]) & mask;
    else if (dir_down[ch]) v = (m_cur[i][ch] - m_done[i][ch]) & mask;
    else v = (m_cur[i][ch] + m_done[i][ch]) & mask;
    v = v >> i;
    return m_ff[i] ? ((v >> 8) & 255) : (v & 255);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    for (int i = 0; i < 2; i++) begin
      if (!rst_n) begin
        m_ff[i] = 0;
        for (int c = 0; c < 4; c++) begin
          m_ba[i][c] = 0; m_bc[i][c] = 0; m_cur[i][c] = 0; m_done[i][c] = 0;
        end
      end else begin
        int ch;
        bit rl;
        ch = int'(ofs[2:1]);
        rl = 0;
        if (ptr_clr) m_ff[i] = 0;
        else begin
          if (wr_en) begin
            if (ofs[0]) m_bc[i][ch] = m_ff[i] ? ((m_bc[i][ch] & 255) | (int'(wdata) << 8))
                                              : ((m_bc[i][ch] & 'hFF00) | int'(wdata));
            else        m_ba[i][ch] = m_ff[i] ? ((m_ba[i][ch] & 255) | (int'(wdata) << 8))
                                              : ((m_ba[i][ch] & 'hFF00) | int'(wdata));
            if (m_ff[i] != 0) begin
              rl = 1;
              m_cur[i][ch]  = m_ba[i][ch] << i;
              m_done[i][ch] = 0;
            end
          end
          if (wr_en || rd_en) m_ff[i] = 1 - m_ff[i];
        end
        for (int c = 0; c < 4; c++)
          if (xfer_stb[c] && !(rl && c == ch))
            m_done[i][c] = (m_done[i][c] + 1) & ((1 << (16 + i)) - 1);
      end
    end
  end

  // compare both instances every clock, just before the rising edge
  always @(negedge clk) begin
    #4;
    n_tests++;
    if (int'(rdata_b) != expect_rd(0)) begin
      n_fail++;
      $display("FAIL %s byte-mode rdata actual=%02h expected=%02h t=%0t",
               cur_req, rdata_b, expect_rd(0), $time);
    end
    n_tests++;
    if (int'(rdata_w) != expect_rd(1)) begin
      n_fail++;
      $display("FAIL R10/%s word-mode rdata actual=%02h expected=%02h t=%0t",
               cur_req, rdata_w, expect_rd(1), $time);
    end
  end

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      wr_en = 0; rd_en = 0; ptr_clr = 0; xfer_stb = '0;
    end
  endtask

  task automatic wr(logic [2:0] o, logic [7:0] d);
    @(negedge clk);
    ofs = o; wdata = d; wr_en = 1; rd_en = 0; ptr_clr = 0; xfer_stb = '0;
  endtask

  task automatic rd(logic [2:0] o);
    @(negedge clk);
    ofs = o; wr_en = 0; rd_en = 1; ptr_clr = 0; xfer_stb = '0;
  endtask

  task automatic clr();
    @(negedge clk);
    wr_en = 0; rd_en = 0; ptr_clr = 1; xfer_stb = '0;
  endtask

  task automatic stb(logic [3:0] m, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      wr_en = 0; rd_en = 0; ptr_clr = 0; xfer_stb = m;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(4);
    cur_req = "R9";  rd(0); rd(0); rd(7); rd(7);
    // R1, R3: channel 1 address = 0x1234, count = 0x0010
    cur_req = "R3";  wr(2, 8'h34); wr(2, 8'h12);
    cur_req = "R1";  rd(2); rd(2); wr(3, 8'h10); wr(3, 8'h00); rd(3); rd(3);
    // R8: three bytes moved on channel 1, none elsewhere
    cur_req = "R8";  stb(4'b0010, 3); idle(1); rd(3); rd(3); rd(1); rd(1);
    cur_req = "R5";  rd(3); rd(3);
    cur_req = "R6";  rd(2); rd(2);
    dir_down = 4'b0010; rd(2); rd(2);
    // R4: low byte alone does not reload
    cur_req = "R4";  wr(2, 8'h00); clr(); rd(2); rd(2);
    wr(2, 8'h99); wr(2, 8'h77); rd(2); rd(2); rd(3); rd(3);
    // R7: clear realigns; clear wins over a colliding write
    cur_req = "R7";  wr(0, 8'hAA); clr(); wr(0, 8'h55); wr(0, 8'h66); rd(0); rd(0);
    @(negedge clk); ofs = 3'd0; wdata = 8'hEE; wr_en = 1; ptr_clr = 1;
    idle(1); rd(0); rd(0);
    cur_req = "R2";  rd(1); wr(1, 8'h21); rd(1); rd(1);
    // R5: count wraps below zero on channel 3
    cur_req = "R5";  wr(7, 8'h00); wr(7, 8'h00); stb(4'b1000, 2); idle(1); rd(7); rd(7);
    // R8: reload and strobe in the same cycle on channel 2
    cur_req = "R8";  wr(5, 8'h08);
    @(negedge clk); ofs = 3'd5; wdata = 8'h00; wr_en = 1; xfer_stb = 4'b0100;
    idle(1); rd(5); rd(5); stb(4'b0100, 1); idle(1); rd(5); rd(5);
    cur_req = "R6";  dir_down = 4'b0000; wr(4, 8'h02); wr(4, 8'h00); stb(4'b0100, 5);
    dir_down = 4'b0100; idle(1); rd(4); rd(4);
    cur_req = "R10"; rd(4); rd(4); rd(5); rd(5);
    idle(3);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<=20000 cycles", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule